// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the stream of column addresses a synchronous DRAM burst visits. A start strobe captures a start column, a burst length code and an ordering selector. From the next clock on, the block presents one column address per cycle with a valid flag, and a last flag on the final beat of a fixed-length burst. Fixed lengths of 1, 2, 4 and 8 stay inside the aligned block that holds the start column. Sequential ordering counts upward and wraps inside that block. Interleaved ordering XORs the start column's low bits with the beat number. A full-page burst walks all 256 columns modulo 256 and keeps going until it is stopped or replaced.

A stop strobe ends the burst at once. The beat shown in the stop cycle is already withdrawn, so write data presented from that cycle on is never used. A new start strobe during a burst replaces it on the next cycle. Interleaved ordering is not defined for full page. If that setting is requested, the burst runs sequentially and an error flag is raised.

The controller has two states. `ST_IDLE` emits nothing. `ST_RUN` emits one beat per cycle. The transitions are: launch (`ST_IDLE` to `ST_RUN` on start), advance (stay in `ST_RUN` and step the beat), finish (`ST_RUN` to `ST_IDLE` after the final beat of a fixed length), halt (`ST_RUN` to `ST_IDLE` on stop), and restart (stay in `ST_RUN`, reload on start).

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o`, `last_o` and `cfg_err_o` are 0.
- R2: When `start_i` is high at a clock edge, the next cycle shows `valid_o`=1 and `col_o` equal to the captured start column, in every ordering and length.
- R3: `len_sel_i` codes 0, 1, 2 and 3 select lengths 1, 2, 4 and 8, and codes 4 to 7 select full page. A fixed-length burst with no interruption shows exactly that many valid beats, with `last_o`=1 only on the final one, and is idle in the cycle after it.
- R4: Sequential ordering (`interleave_i`=0) with length BL emits start+k modulo BL in the low log2(BL) bits for k = 0..BL-1 and keeps the upper column bits of the start column.
- R5: Interleaved ordering (`interleave_i`=1) with a fixed length BL emits the start column's low log2(BL) bits XOR k and keeps the upper bits.
- R6: A full-page burst emits (start+k) modulo 256 for every k, never asserts `last_o`, and does not end by itself.
- R7: A start with `interleave_i`=1 and a full-page code runs as sequential full page and sets `cfg_err_o`=1 from the next cycle. `cfg_err_o` holds until the next start, which sets it again according to that start's settings.
- R8: `stop_i` high during a burst forces `valid_o` and `last_o` to 0 in that same cycle, and the block is idle from the next cycle unless `start_i` was also high.
- R9: `start_i` during a burst takes priority over `stop_i` and over the end of the burst: the next cycle shows beat 0 of the new burst.
- R10: `stop_i` while idle has no effect: `valid_o` stays 0 and `cfg_err_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Column command strobe; captures the burst settings |
| stop_i | input | 1 | Burst-stop strobe |
| start_col_i | input | 8 | Start column |
| len_sel_i | input | 3 | Length code: 0..3 give 1/2/4/8, 4..7 give full page |
| interleave_i | input | 1 | 1 selects interleaved ordering, 0 sequential |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | Column address is a live beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Current burst asked for interleaved full page |

## Verification
The embedded properties watch, on every cycle, the state-level rules: a start always yields its start column one cycle later, the final beat or a stop returns the controller to idle, a full-page burst never ends by itself, and the upper column bits stay fixed between beats of one burst. The exact address orderings cannot be seen from such local rules. These are the wrap inside the aligned block, the XOR pattern, and the modulo-256 walk past column 255. Neither can the same-cycle withdrawal of a stopped beat or the priority of a restart over a stop. The bench's scenarios and its behavioural model are the only checks of these.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bcs_state_e;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W       = 8,
    parameter int LEN_W       = 3,
    parameter int FIXED_CODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_sel_i,
    input  logic             interleave_i,
    output logic             run_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    localparam logic [LEN_W-1:0] FP_CODE = LEN_W'(FIXED_CODES);

    bcs_state_e       state_q, state_d;
    logic [COL_W-1:0] beat_q, base_q, mask_q, mask_new;
    logic             full_q, ilv_q, err_q, full_new, at_end;

    assign full_new = (len_sel_i >= FP_CODE);

    always_comb begin
        mask_new = '0;
        for (int i = 0; i < COL_W; i++) begin
            mask_new[i] = full_new || (i < int'(len_sel_i));
        end
    end

    assign at_end = !full_q && (beat_q == mask_q);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;          // launch
            ST_RUN: begin
                if (start_i)     state_d = ST_RUN;           // restart
                else if (stop_i) state_d = ST_IDLE;          // halt
                else if (at_end) state_d = ST_IDLE;          // finish
                else             state_d = ST_RUN;           // advance
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            base_q <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            beat_q <= '0;
            base_q <= start_col_i;
            mask_q <= mask_new;
            full_q <= full_new;
            ilv_q  <= interleave_i && !full_new;
            err_q  <= interleave_i && full_new;
        end else if (state_q == ST_RUN && state_d == ST_RUN) begin
            beat_q <= beat_q + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        run_o   = (state_q == ST_RUN);
        valid_o = run_o && !stop_i;
        last_o  = valid_o && at_end;
        beat_o  = beat_q;
        base_o  = base_q;
        mask_o  = mask_q;
        ilv_o   = ilv_q;
        err_o   = err_q;
    end

    // R3
    finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> (state_q == ST_IDLE));
    // R8
    halt_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && stop_i && !start_i) |=> (state_q == ST_IDLE));
    // R6
    fullpage_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && full_q && !stop_i) |=> (state_q == ST_RUN));
    // R7
    bad_combo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && interleave_i && full_new) |=> (err_q && !ilv_q));
endmodule

// File: rtl/bcs_addr.sv
module bcs_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum_w, xor_w;

    assign sum_w = base_i + beat_i;
    assign xor_w = base_i ^ beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = !mask_i[b] ? base_i[b] :
                          (ilv_i ? xor_w[b] : sum_w[b]);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W       = 8,
    parameter int LEN_W       = 3,
    parameter int FIXED_CODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_sel_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    logic             run_w, ilv_w;
    logic [COL_W-1:0] beat_w, base_w, mask_w;

    bcs_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W), .FIXED_CODES(FIXED_CODES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .start_col_i  (start_col_i),
        .len_sel_i    (len_sel_i),
        .interleave_i (interleave_i),
        .run_o        (run_w),
        .beat_o       (beat_w),
        .base_o       (base_w),
        .mask_o       (mask_w),
        .ilv_o        (ilv_w),
        .valid_o      (valid_o),
        .last_o       (last_o),
        .err_o        (cfg_err_o)
    );

    bcs_addr #(.COL_W(COL_W)) u_addr (
        .base_i (base_w),
        .beat_i (beat_w),
        .mask_i (mask_w),
        .ilv_i  (ilv_w),
        .col_o  (col_o)
    );

    // R2
    launch_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (run_w && col_o == $past(start_col_i)));
    // R4
    upper_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w) && !$past(start_i))
            |-> (((col_o ^ $past(col_o)) & ~mask_w) == '0));
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, interleave_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_sel_i = '0;
    logic [7:0] col_o;
    logic       valid_o, last_o, cfg_err_o;

    int checks = 0, fails = 0;
    bit finished = 0;

    // behavioural reference state
    int m_busy = 0, m_base = 0, m_beat = 0, m_bl = 0, m_ilv = 0, m_err = 0;

    always #10 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .start_col_i(start_col_i), .len_sel_i(len_sel_i),
        .interleave_i(interleave_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    function automatic int exp_col();
        int off;
        if (m_bl == 0) return (m_base + m_beat) % 256;
        off = m_base % m_bl;
        if (m_ilv != 0) off = off ^ m_beat;
        else            off = (off + m_beat) % m_bl;
        return (m_base - (m_base % m_bl)) + off;
    endfunction

    task automatic compare(string tag);
        int ev, el, ec;
        ev = (m_busy != 0 && !stop_i) ? 1 : 0;
        el = (ev == 1 && m_bl != 0 && m_beat == m_bl - 1) ? 1 : 0;
        ec = exp_col();
        checks++;
        if (valid_o !== ev[0] || last_o !== el[0] || cfg_err_o !== m_err[0] ||
            (ev == 1 && col_o !== ec[7:0])) begin
            fails++;
            $display("FAIL %s: valid/last/err/col = %0b/%0b/%0b/%02h, expected %0d/%0d/%0d/%02h",
                     tag, valid_o, last_o, cfg_err_o, col_o, ev, el, m_err, ec);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_busy = 0; m_base = 0; m_beat = 0; m_bl = 0; m_ilv = 0; m_err = 0;
        end else if (start_i) begin
            m_busy = 1;
            m_base = int'(start_col_i);
            m_beat = 0;
            m_bl   = (len_sel_i < 4) ? (1 << len_sel_i) : 0;
            m_ilv  = (interleave_i && m_bl != 0) ? 1 : 0;
            m_err  = (interleave_i && m_bl == 0) ? 1 : 0;
        end else if (m_busy != 0) begin
            if (stop_i)                                 m_busy = 0;
            else if (m_bl != 0 && m_beat == m_bl - 1)   m_busy = 0;
            else                                        m_beat = (m_beat + 1) % 256;
        end
    endtask

    task automatic cyc(bit s, bit p, logic [7:0] c, logic [2:0] l, bit i, string tag);
        start_i = s; stop_i = p; start_col_i = c; len_sel_i = l; interleave_i = i;
        @(negedge clk);
        compare(tag);
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 3'd0, 0, tag);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        // R1: reset state
        for (int k = 0; k < 3; k++) cyc(0, 0, 8'h00, 3'd0, 0, "R1");
        rst_n = 1'b1;
        idle(2, "R1");

        // R2 R4: sequential length 4 from 0x26 -> 26 27 24 25
        cyc(1, 0, 8'h26, 3'd2, 0, "R2");
        idle(5, "R4");
        // R5: interleaved length 8 from 0x5B
        cyc(1, 0, 8'h5B, 3'd3, 1, "R2");
        idle(9, "R5");
        // R3: lengths 1 and 2 at top of space
        cyc(1, 0, 8'hFF, 3'd0, 0, "R3");
        idle(2, "R3");
        cyc(1, 0, 8'hFF, 3'd1, 0, "R3");
        idle(3, "R3");
        cyc(1, 0, 8'h0D, 3'd1, 1, "R5");
        idle(3, "R5");
        cyc(1, 0, 8'h11, 3'd3, 0, "R4");
        idle(9, "R4");

        // R6: full page wraps past 255 and never ends by itself
        cyc(1, 0, 8'hFC, 3'd4, 0, "R6");
        idle(300, "R6");
        // R8: stop withdraws the beat in the same cycle
        cyc(0, 1, 8'h00, 3'd0, 0, "R8");
        idle(2, "R8");

        // R7: interleave with full page (reserved code 6) runs sequential, flags error
        cyc(1, 0, 8'h3E, 3'd6, 1, "R7");
        idle(6, "R7");
        cyc(0, 1, 8'h00, 3'd0, 0, "R7");
        // R10: idle stop keeps the error flag and emits nothing
        cyc(0, 1, 8'h00, 3'd0, 0, "R10");
        cyc(0, 1, 8'h77, 3'd2, 1, "R10");
        idle(1, "R10");
        cyc(1, 0, 8'h40, 3'd2, 0, "R7");
        idle(5, "R7");

        // R8: stop during beat 3 of length 8
        cyc(1, 0, 8'hA0, 3'd3, 1, "R8");
        idle(3, "R8");
        cyc(0, 1, 8'h00, 3'd0, 0, "R8");
        idle(2, "R8");

        // R9: restart mid burst, and restart with stop in the same cycle
        cyc(1, 0, 8'h80, 3'd3, 0, "R9");
        idle(2, "R9");
        cyc(1, 0, 8'h33, 3'd2, 1, "R9");
        idle(1, "R9");
        cyc(1, 1, 8'hC7, 3'd1, 0, "R9");
        idle(1, "R9");
        // R9: restart on the last beat
        cyc(1, 0, 8'h04, 3'd1, 0, "R9");
        cyc(0, 0, 8'h00, 3'd0, 0, "R9");
        cyc(1, 0, 8'h09, 3'd0, 0, "R9");
        idle(3, "R9");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule